// File: doc/BRIEF.md
# Downstream Port Power Controller

This block drives the power-enable outputs of a hub's downstream ports. Each port also has an over-current input from its external power switch. Hub logic asks for power to be turned on or off with single-cycle request pulses, one pair per port. The block turns those pulses into stable enable levels. It watches the active-low over-current inputs, which are asynchronous. Each input is synchronized and then filtered, so that short glitches are ignored. When a fault is accepted, power is removed and a sticky status bit records it.

A static configuration input selects one of two modes. In grouped mode all ports behave as one supply: any request or any fault acts on every port in the same cycle. In independent mode each port has its own enable, its own over-current input and its own status bit. After a fault a port does not restart by itself. It stays off until the fault has cleared and hub logic sends a fresh power-on request.

Top module: `port_power_ctl`

## Requirements
- R1: After reset every `pwr_en_o` bit and every `oc_status_o` bit is 0.
- R2: An over-current input (`oc_n_i`, low means fault) is accepted only after its synchronized value has been low for FILT_CYCLES consecutive clock cycles. A low pulse that lasts fewer cycles has no effect on enables or status. For a sustained low level applied between two clock edges, the affected enable falls on the FILT_CYCLES+3rd rising edge after the input goes low.
- R3: In independent mode (`ganged_i` = 0), an accepted fault on port i clears only `pwr_en_o[i]`. The other ports keep their state.
- R4: In grouped mode (`ganged_i` = 1), an accepted fault on any port clears all `pwr_en_o` bits on the same edge and sets all `oc_status_o` bits.
- R5: In independent mode, a one-cycle pulse on `pwr_on_req_i[i]` sets `pwr_en_o[i]` on the next edge, and a pulse on `pwr_off_req_i[i]` clears it. If both requests are present in the same cycle, the off request wins.
- R6: In grouped mode, an on or off request on any port bit applies to all ports.
- R7: A faulted port stays off while its fault is present, and power-on requests made during that time are ignored. Once the fault has cleared, a new power-on request powers the port again.
- R8: `oc_status_o[i]` is set whenever a fault is accepted on port i, even if the port was unpowered. It stays set until `oc_clr_i` is pulsed, and that clear acts on all bits. If a fault is still present while the clear is pulsed, the set wins and the bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ganged_i | input | 1 | 1 = grouped mode, 0 = independent per-port mode |
| pwr_on_req_i | input | NPORTS | Per-port power-on request pulses |
| pwr_off_req_i | input | NPORTS | Per-port power-off request pulses |
| oc_n_i | input | NPORTS | Asynchronous active-low over-current inputs |
| oc_clr_i | input | 1 | Clear strobe for all over-current status bits |
| pwr_en_o | output | NPORTS | Per-port power-enable outputs |
| oc_status_o | output | NPORTS | Sticky per-port over-current status |

## Verification
The bench builds the block with NPORTS = 7 and FILT_CYCLES = 3. The short filter lets both sides of the acceptance threshold be reached in a few cycles: a pulse of FILT_CYCLES-1 cycles is ignored, and a sustained level is checked at the exact edge where the enable falls. Seven ports allow the bench to fault one port while a non-adjacent port stays powered, to fault an unpowered port, and to check in grouped mode that a fault on the highest port clears the lowest one.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

  typedef enum logic [1:0] {
    PS_OFF   = 2'd0,
    PS_ON    = 2'd1,
    PS_FAULT = 2'd2
  } pwr_state_e;

endpackage

// File: rtl/ppc_rst_sync.sv
module ppc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync_o = stage_q[1];

endmodule

// File: rtl/ppc_oc_filter.sv
module ppc_oc_filter #(
  parameter int FILT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_n_i,
  output logic fault_o
);

  localparam int CNT_W = $clog2(FILT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILT_CYCLES);

  logic [1:0]       sync_q;
  logic             active;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // two-flop synchronizer, resets to the idle (high) level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
    end else begin
      sync_q <= {sync_q[0], oc_n_i};
    end
  end

  assign active = ~sync_q[1];

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!active) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign fault_o = (cnt_q == CNT_MAX);

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);  // R2

  AST_FAULT_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> $past(active));  // R2

endmodule

// File: rtl/ppc_port_fsm.sv
module ppc_port_fsm
  import ppc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic on_req_i,
  input  logic off_req_i,
  input  logic fault_i,
  output logic pwr_en_o
);

  pwr_state_e state_q;
  pwr_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_OFF: begin
        if (fault_i) begin
          state_d = PS_FAULT;
        end else if (on_req_i && !off_req_i) begin
          state_d = PS_ON;
        end
      end
      PS_ON: begin
        if (fault_i) begin
          state_d = PS_FAULT;
        end else if (off_req_i) begin
          state_d = PS_OFF;
        end
      end
      PS_FAULT: begin
        if (!fault_i) begin
          state_d = PS_OFF;
        end
      end
      default: state_d = PS_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_OFF;
    end else begin
      state_q <= state_d;
    end
  end

  assign pwr_en_o = (state_q == PS_ON);

  AST_FAULT_CUTS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> !pwr_en_o);  // R3

  AST_ON_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en_o) |-> ($past(on_req_i) && !$past(off_req_i)));  // R5

  AST_OFF_REQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    off_req_i |=> !pwr_en_o);  // R5

  AST_FAULT_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_FAULT) |=> !pwr_en_o);  // R7

endmodule

// File: rtl/ppc_oc_status.sv
module ppc_oc_status #(
  parameter int NPORTS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] set_i,
  input  logic              clr_i,
  output logic [NPORTS-1:0] status_o
);

  logic [NPORTS-1:0] st_q;
  logic [NPORTS-1:0] st_d;
  logic              st_en;

  always_comb begin
    st_en = clr_i || (set_i != '0);
    st_d  = set_i | (st_q & {NPORTS{~clr_i}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  assign status_o = st_q;

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((st_q & $past(st_q)) == $past(st_q)));  // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((st_q & $past(set_i)) == $past(set_i)));  // R8

  AST_CLEAR_ONLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_i == '0) |=> (st_q == '0));  // R8

endmodule

// File: rtl/port_power_ctl.sv
module port_power_ctl #(
  parameter int NPORTS      = 7,
  parameter int FILT_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ganged_i,
  input  logic [NPORTS-1:0] pwr_on_req_i,
  input  logic [NPORTS-1:0] pwr_off_req_i,
  input  logic [NPORTS-1:0] oc_n_i,
  input  logic              oc_clr_i,
  output logic [NPORTS-1:0] pwr_en_o,
  output logic [NPORTS-1:0] oc_status_o
);

  logic              rst_n_int;
  logic [NPORTS-1:0] flt_raw;
  logic [NPORTS-1:0] grp_flt;
  logic [NPORTS-1:0] grp_on;
  logic [NPORTS-1:0] grp_off;

  ppc_rst_sync i_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_int)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_filt
    ppc_oc_filter #(
      .FILT_CYCLES (FILT_CYCLES)
    ) i_filt (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .oc_n_i  (oc_n_i[p]),
      .fault_o (flt_raw[p])
    );
  end

  // mode selection: grouped mode broadcasts any bit to every port
  always_comb begin
    if (ganged_i) begin
      grp_flt = {NPORTS{|flt_raw}};
      grp_on  = {NPORTS{|pwr_on_req_i}};
      grp_off = {NPORTS{|pwr_off_req_i}};
    end else begin
      grp_flt = flt_raw;
      grp_on  = pwr_on_req_i;
      grp_off = pwr_off_req_i;
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    ppc_port_fsm i_fsm (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .on_req_i  (grp_on[p]),
      .off_req_i (grp_off[p]),
      .fault_i   (grp_flt[p]),
      .pwr_en_o  (pwr_en_o[p])
    );
  end

  ppc_oc_status #(
    .NPORTS (NPORTS)
  ) i_status (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .set_i    (grp_flt),
    .clr_i    (oc_clr_i),
    .status_o (oc_status_o)
  );

  AST_GANG_FAULT_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ganged_i && (flt_raw != '0)) |=> (pwr_en_o == '0));  // R4

  AST_GANG_FAULT_ALL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ganged_i && (flt_raw != '0)) |=> (&oc_status_o));  // R4

  AST_GANG_OFF_ALL: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ganged_i && (pwr_off_req_i != '0)) |=> (pwr_en_o == '0));  // R6

  AST_INDEP_FAULT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!ganged_i && (flt_raw == '0) && (pwr_off_req_i == '0))
      |=> ((pwr_en_o & $past(pwr_en_o)) == $past(pwr_en_o)));  // R3

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n_int |-> (pwr_en_o == '0 && oc_status_o == '0));  // R1

endmodule

// File: tb/test_port_power_ctl.sv
module test_port_power_ctl;

  localparam int N = 7;
  localparam int F = 3;

  logic         clk;
  logic         rst_n;
  logic         ganged;
  logic [N-1:0] on_req;
  logic [N-1:0] off_req;
  logic [N-1:0] oc_n;
  logic         oc_clr;
  logic [N-1:0] pwr_en;
  logic [N-1:0] oc_status;

  typedef struct {
    int           due;
    logic [N-1:0] en;
    logic [N-1:0] st;
    string        req;
  } exp_t;

  exp_t q[$];
  int   cyc;
  int   checks;
  int   errors;

  port_power_ctl #(
    .NPORTS      (N),
    .FILT_CYCLES (F)
  ) i_port_power_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .ganged_i      (ganged),
    .pwr_on_req_i  (on_req),
    .pwr_off_req_i (off_req),
    .oc_n_i        (oc_n),
    .oc_clr_i      (oc_clr),
    .pwr_en_o      (pwr_en),
    .oc_status_o   (oc_status)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int dly, input logic [N-1:0] en,
                           input logic [N-1:0] st, input string req);
    exp_t e;
    e.due = cyc + dly;
    e.en  = en;
    e.st  = st;
    e.req = req;
    q.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares outputs against scoreboard entries due this cycle
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        checks++;
        if (pwr_en !== q[i].en || oc_status !== q[i].st) begin
          errors++;
          $display("FAIL %s cycle %0d: en=%b st=%b expected en=%b st=%b",
                   q[i].req, cyc, pwr_en, oc_status, q[i].en, q[i].st);
        end
        q.delete(i);
      end
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    checks  = 0;
    errors  = 0;
    rst_n   = 1'b0;
    ganged  = 1'b0;
    on_req  = '0;
    off_req = '0;
    oc_n    = '1;
    oc_clr  = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1: quiet after reset
    expect_at(1, 7'b0000000, 7'b0000000, "R1");
    tick(2);

    // R5: independent on requests
    on_req = 7'b0000101;
    expect_at(1, 7'b0000101, 7'b0000000, "R5");
    tick(1); on_req = '0; tick(1);

    // R5: off wins on port 2, port 5 turns on
    on_req  = 7'b0100100;
    off_req = 7'b0000100;
    expect_at(1, 7'b0100001, 7'b0000000, "R5");
    tick(1); on_req = '0; off_req = '0; tick(1);

    // R2: glitch shorter than the filter is ignored
    oc_n[0] = 1'b0;
    tick(F - 1);
    oc_n[0] = 1'b1;
    expect_at(F + 4, 7'b0100001, 7'b0000000, "R2");
    tick(F + 6);

    // R2 and R3: sustained fault on port 0, exact edge, port 5 unaffected
    oc_n[0] = 1'b0;
    expect_at(F + 2, 7'b0100001, 7'b0000000, "R2");
    expect_at(F + 3, 7'b0100000, 7'b0000001, "R3");
    tick(F + 4);

    // R7: on request ignored while fault is present
    on_req = 7'b0000001;
    expect_at(1, 7'b0100000, 7'b0000001, "R7");
    tick(1); on_req = '0; tick(1);

    // R7: fault gone, fresh request restores power
    oc_n[0] = 1'b1;
    tick(5);
    on_req = 7'b0000001;
    expect_at(1, 7'b0100001, 7'b0000001, "R7");
    tick(1); on_req = '0; tick(1);

    // R8: clear strobe
    oc_clr = 1'b1;
    expect_at(1, 7'b0100001, 7'b0000000, "R8");
    tick(1); oc_clr = 1'b0; tick(1);

    // R8: fault on an unpowered port still sets status
    oc_n[3] = 1'b0;
    expect_at(F + 3, 7'b0100001, 7'b0001000, "R8");
    tick(F + 4);

    // R8: set wins over clear while fault persists
    oc_clr = 1'b1;
    expect_at(1, 7'b0100001, 7'b0001000, "R8");
    tick(1); oc_clr = 1'b0; oc_n[3] = 1'b1;
    tick(6);
    oc_clr = 1'b1;
    expect_at(1, 7'b0100001, 7'b0000000, "R8");
    tick(1); oc_clr = 1'b0; tick(1);

    // R6: grouped requests
    ganged = 1'b1;
    tick(1);
    off_req = 7'b1000000;
    expect_at(1, 7'b0000000, 7'b0000000, "R6");
    tick(1); off_req = '0; tick(1);
    on_req = 7'b0010000;
    expect_at(1, 7'b1111111, 7'b0000000, "R6");
    tick(1); on_req = '0; tick(1);

    // R4: grouped fault on port 6 drops every port together
    oc_n[6] = 1'b0;
    expect_at(F + 2, 7'b1111111, 7'b0000000, "R4");
    expect_at(F + 3, 7'b0000000, 7'b1111111, "R4");
    tick(F + 4);
    oc_n[6] = 1'b1;
    tick(6);

    if (q.size() != 0) begin
      errors++;
      $display("FAIL R1 scoreboard: %0d pending, expected 0", q.size());
    end
    summary();
    $finish;
  end

endmodule